// File: doc/BRIEF.md
# Virtual Wire Group Receiver

This block holds one group of four controller-to-target virtual wires on the embedded-controller side of a host link. Upstream logic decodes the serial bus and presents a group update. The update carries a host index, four wire values and a valid bit for each wire. The block applies an update only when its index equals the group's stored 8-bit host index. It keeps the four wire states, and it loads programmable default states when the reset event chosen for the group arrives.

Each wire has its own interrupt mode. A wire can raise a sticky status bit on a low level, a high level, a rising edge, a falling edge or either edge. Firmware clears status by writing one to the bit. The group interrupt is the OR over the four wires of status AND enable. A small register port lets firmware program the host index, the reset source, the reset states, the modes and the enables. Firmware can also force selected wire values through a masked write and read back every state.

Top module: `vw_group_rx`

## Requirements
- R1: After `rst_ni` low, all wires read 0, all status and enable bits are 0, `irq_o` is 0, and register 0 reads the host index parameter with reset source 0 and reset states 0.
- R2: A host update with `upd_valid_i` high and `upd_index_i` equal to the stored host index sets wire n to `upd_wire_val_i[n]` for each n with `upd_wire_vld_i[n]` = 1. Wires with valid bit 0 keep their value. The new value is visible after the next clock edge.
- R3: A host update is ignored when its index differs from the stored host index or when `upd_valid_i` is low.
- R4: Register 0 bits [9:8] choose the reset source (0..3), and `rst_evt_i[sel]` is the selected event. While the selected event is high, the wires load register 0 bits [15:12] (bit 12+n is the reset state of wire n). Events on unselected lines have no effect.
- R5: A write to register 1 is a masked source write. Wire n takes write-data bit n+4 only when bit n is 1. A read of register 1 returns the wire states in bits [3:0].
- R6: In a single cycle, a firmware source write overrides a host update for the wires it masks, and the selected reset event overrides both.
- R7: Register 2 holds 3-bit mode codes, with wire n at bits [3n+2:3n]. Code 3 detects rising edges, code 4 falling edges and code 5 both edges. The status bit of wire n is set on the same clock edge that applies the matching change.
- R8: Code 1 (low level) and code 2 (high level) set status while the wire is at that level. A clear written while the level is still present leaves the bit set. Once the level is gone, the clear takes effect.
- R9: Codes 0, 6 and 7 never set status. A change of mode code by itself creates no edge event.
- R10: Register 3 returns status in bits [3:0]. Writing 1 to bit n clears status n and writing 0 leaves it alone. If a set condition falls in the same cycle as a clear, the bit stays set.
- R11: Register 4 bits [3:0] are the per-wire enables, and `irq_o` is high exactly when some wire has both status and enable set.
- R12: Register 0 bits [7:0] hold the host index and read back as written, along with the reset source and reset state fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low block reset |
| rst_evt_i | input | 4 | Reset event lines: bus, system, peripheral I/O, platform |
| upd_valid_i | input | 1 | Host update present this cycle |
| upd_index_i | input | 8 | Host index of the update |
| upd_wire_vld_i | input | 4 | Per-wire valid bits of the update |
| upd_wire_val_i | input | 4 | Per-wire values of the update |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from addr) |
| wire_o | output | 4 | Current wire states |
| irq_o | output | 1 | Group interrupt |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a firmware clear of a status bit and an edge that sets the same bit. The second is a host update and a firmware source write, or a reset event, aimed at the same wire. The bench drives a falling-edge host update together with a one-to-clear on that wire's status and expects the bit to survive. It then drives a host update, a masked source write and the selected reset event together and checks the resulting wire states against the stated priority.

// File: rtl/vwg_pkg.sv
`timescale 1ns/1ps
package vwg_pkg;
   localparam int MODE_W  = 3;
   localparam int RSEL_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF  = 3'd0,
      MODE_LOW  = 3'd1,
      MODE_HIGH = 3'd2,
      MODE_RISE = 3'd3,
      MODE_FALL = 3'd4,
      MODE_BOTH = 3'd5
   } irq_mode_e;

   localparam int REG_CFG  = 0;
   localparam int REG_SRC  = 1;
   localparam int REG_MODE = 2;
   localparam int REG_STAT = 3;
   localparam int REG_EN   = 4;
endpackage

// File: rtl/vwg_cfg_regs.sv
`timescale 1ns/1ps
module vwg_cfg_regs
   import vwg_pkg::*;
#(
   parameter int NUM_WIRES = 4,
   parameter int IDX_W = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter logic [IDX_W-1:0] INIT_HOST_IDX = '0
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        reg_we_i,
   input  logic [ADDR_W-1:0]           reg_addr_i,
   input  logic [DATA_W-1:0]           reg_wdata_i,
   input  logic [NUM_WIRES-1:0]        wires_i,
   input  logic [NUM_WIRES-1:0]        status_i,
   output logic [DATA_W-1:0]           reg_rdata_o,
   output logic [IDX_W-1:0]            host_idx_o,
   output logic [RSEL_W-1:0]           rst_sel_o,
   output logic [NUM_WIRES-1:0]        rst_vals_o,
   output logic [NUM_WIRES*MODE_W-1:0] modes_o,
   output logic [NUM_WIRES-1:0]        en_o,
   output logic                        src_wr_o,
   output logic [NUM_WIRES-1:0]        src_mask_o,
   output logic [NUM_WIRES-1:0]        src_vals_o,
   output logic [NUM_WIRES-1:0]        clr_o
);
   localparam int RSEL_LO = IDX_W;
   localparam int RVAL_LO = IDX_W + 4;
   localparam int MODES_W = NUM_WIRES * MODE_W;

   if (RVAL_LO + NUM_WIRES > DATA_W) begin : g_cfg_too_wide
      $error("vwg_cfg_regs: configuration fields exceed DATA_W");
   end
   if (MODES_W > DATA_W) begin : g_modes_too_wide
      $error("vwg_cfg_regs: mode field exceeds DATA_W");
   end
   if (2 * NUM_WIRES > DATA_W) begin : g_src_too_wide
      $error("vwg_cfg_regs: source write exceeds DATA_W");
   end

   logic [IDX_W-1:0]     host_idx_q;
   logic [RSEL_W-1:0]    rst_sel_q;
   logic [NUM_WIRES-1:0] rst_vals_q;
   logic [MODES_W-1:0]   modes_q;
   logic [NUM_WIRES-1:0] en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         host_idx_q <= INIT_HOST_IDX;
         rst_sel_q  <= '0;
         rst_vals_q <= '0;
         modes_q    <= '0;
         en_q       <= '0;
      end else if (reg_we_i) begin
         case (reg_addr_i)
            ADDR_W'(REG_CFG): begin
               host_idx_q <= reg_wdata_i[IDX_W-1:0];
               rst_sel_q  <= reg_wdata_i[RSEL_LO +: RSEL_W];
               rst_vals_q <= reg_wdata_i[RVAL_LO +: NUM_WIRES];
            end
            ADDR_W'(REG_MODE): modes_q <= reg_wdata_i[MODES_W-1:0];
            ADDR_W'(REG_EN):   en_q    <= reg_wdata_i[NUM_WIRES-1:0];
            default: ;
         endcase
      end
   end

   assign src_wr_o   = reg_we_i && (reg_addr_i == ADDR_W'(REG_SRC));
   assign src_mask_o = reg_wdata_i[NUM_WIRES-1:0];
   assign src_vals_o = reg_wdata_i[NUM_WIRES +: NUM_WIRES];
   assign clr_o      = (reg_we_i && (reg_addr_i == ADDR_W'(REG_STAT)))
                       ? reg_wdata_i[NUM_WIRES-1:0] : '0;

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(REG_CFG): begin
            reg_rdata_o[IDX_W-1:0]             = host_idx_q;
            reg_rdata_o[RSEL_LO +: RSEL_W]     = rst_sel_q;
            reg_rdata_o[RVAL_LO +: NUM_WIRES]  = rst_vals_q;
         end
         ADDR_W'(REG_SRC):  reg_rdata_o[NUM_WIRES-1:0] = wires_i;
         ADDR_W'(REG_MODE): reg_rdata_o[MODES_W-1:0]   = modes_q;
         ADDR_W'(REG_STAT): reg_rdata_o[NUM_WIRES-1:0] = status_i;
         ADDR_W'(REG_EN):   reg_rdata_o[NUM_WIRES-1:0] = en_q;
         default: ;
      endcase
   end

   assign host_idx_o = host_idx_q;
   assign rst_sel_o  = rst_sel_q;
   assign rst_vals_o = rst_vals_q;
   assign modes_o    = modes_q;
   assign en_o       = en_q;
endmodule

// File: rtl/vwg_wire_store.sv
`timescale 1ns/1ps
module vwg_wire_store
   import vwg_pkg::*;
#(
   parameter int NUM_WIRES = 4,
   parameter int IDX_W = 8
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   upd_valid_i,
   input  logic [IDX_W-1:0]       upd_index_i,
   input  logic [NUM_WIRES-1:0]   upd_vld_i,
   input  logic [NUM_WIRES-1:0]   upd_val_i,
   input  logic [IDX_W-1:0]       host_idx_i,
   input  logic [(1<<RSEL_W)-1:0] rst_evt_i,
   input  logic [RSEL_W-1:0]      rst_sel_i,
   input  logic [NUM_WIRES-1:0]   rst_vals_i,
   input  logic                   src_wr_i,
   input  logic [NUM_WIRES-1:0]   src_mask_i,
   input  logic [NUM_WIRES-1:0]   src_vals_i,
   output logic [NUM_WIRES-1:0]   wire_q_o,
   output logic [NUM_WIRES-1:0]   wire_d_o
);
   logic [NUM_WIRES-1:0] wire_q;
   logic [NUM_WIRES-1:0] wire_d;
   logic                 host_hit;
   logic                 rst_hit;

   assign host_hit = upd_valid_i && (upd_index_i == host_idx_i);
   assign rst_hit  = rst_evt_i[rst_sel_i];

   // lowest priority first: host update, firmware write, reset event
   always_comb begin
      wire_d = wire_q;
      if (host_hit) wire_d = (wire_d & ~upd_vld_i) | (upd_val_i & upd_vld_i);
      if (src_wr_i) wire_d = (wire_d & ~src_mask_i) | (src_vals_i & src_mask_i);
      if (rst_hit)  wire_d = rst_vals_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wire_q <= '0;
      else         wire_q <= wire_d;
   end

   assign wire_q_o = wire_q;
   assign wire_d_o = wire_d;
endmodule

// File: rtl/vwg_irq_detect.sv
`timescale 1ns/1ps
module vwg_irq_detect
   import vwg_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              cur_i,
   input  logic              nxt_i,
   input  logic              clr_i,
   output logic              status_o
);
   logic rise, fall, hit, status_q;

   assign rise = ~cur_i & nxt_i;
   assign fall = cur_i & ~nxt_i;

   always_comb begin
      case (mode_i)
         MODE_LOW:  hit = ~nxt_i;
         MODE_HIGH: hit = nxt_i;
         MODE_RISE: hit = rise;
         MODE_FALL: hit = fall;
         MODE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   // a set in the same cycle as a clear wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= 1'b0;
      else         status_q <= (status_q & ~clr_i) | hit;
   end

   assign status_o = status_q;
endmodule

// File: rtl/vw_group_rx.sv
`timescale 1ns/1ps
module vw_group_rx
   import vwg_pkg::*;
#(
   parameter int NUM_WIRES = 4,
   parameter int IDX_W = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter logic [IDX_W-1:0] INIT_HOST_IDX = '0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [3:0]           rst_evt_i,
   input  logic                 upd_valid_i,
   input  logic [IDX_W-1:0]     upd_index_i,
   input  logic [NUM_WIRES-1:0] upd_wire_vld_i,
   input  logic [NUM_WIRES-1:0] upd_wire_val_i,
   input  logic                 reg_we_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [DATA_W-1:0]    reg_wdata_i,
   output logic [DATA_W-1:0]    reg_rdata_o,
   output logic [NUM_WIRES-1:0] wire_o,
   output logic                 irq_o
);
   localparam int NUM_RST = 1 << RSEL_W;

   if (NUM_RST != 4) begin : g_bad_rst
      $error("vw_group_rx: reset event width mismatch");
   end

   logic [IDX_W-1:0]            host_idx;
   logic [RSEL_W-1:0]           rst_sel;
   logic [NUM_WIRES-1:0]        rst_vals;
   logic [NUM_WIRES*MODE_W-1:0] modes;
   logic [NUM_WIRES-1:0]        en;
   logic                        src_wr;
   logic [NUM_WIRES-1:0]        src_mask, src_vals, clr;
   logic [NUM_WIRES-1:0]        wire_q, wire_d, status;

   vwg_cfg_regs #(
      .NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .INIT_HOST_IDX(INIT_HOST_IDX)
   ) u_regs (
      .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
      .wires_i(wire_q), .status_i(status), .reg_rdata_o,
      .host_idx_o(host_idx), .rst_sel_o(rst_sel), .rst_vals_o(rst_vals),
      .modes_o(modes), .en_o(en), .src_wr_o(src_wr),
      .src_mask_o(src_mask), .src_vals_o(src_vals), .clr_o(clr)
   );

   vwg_wire_store #(.NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W)) u_store (
      .clk_i, .rst_ni, .upd_valid_i, .upd_index_i,
      .upd_vld_i(upd_wire_vld_i), .upd_val_i(upd_wire_val_i),
      .host_idx_i(host_idx), .rst_evt_i(rst_evt_i[NUM_RST-1:0]),
      .rst_sel_i(rst_sel), .rst_vals_i(rst_vals),
      .src_wr_i(src_wr), .src_mask_i(src_mask), .src_vals_i(src_vals),
      .wire_q_o(wire_q), .wire_d_o(wire_d)
   );

   for (genvar gi = 0; gi < NUM_WIRES; gi++) begin : g_wire
      vwg_irq_detect u_det (
         .clk_i, .rst_ni,
         .mode_i(modes[gi*MODE_W +: MODE_W]),
         .cur_i(wire_q[gi]), .nxt_i(wire_d[gi]),
         .clr_i(clr[gi]), .status_o(status[gi])
      );
   end

   assign wire_o = wire_q;
   assign irq_o  = |(status & en);
endmodule

// File: rtl/vwg_checker.sv
`timescale 1ns/1ps
module vwg_checker
   import vwg_pkg::*;
#(
   parameter int NUM_WIRES = 4,
   parameter int IDX_W = 8,
   parameter int ADDR_W = 3
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic [3:0]                  rst_evt_i,
   input logic                        upd_valid_i,
   input logic [IDX_W-1:0]            upd_index_i,
   input logic [NUM_WIRES-1:0]        upd_wire_vld_i,
   input logic [NUM_WIRES-1:0]        upd_wire_val_i,
   input logic                        reg_we_i,
   input logic [ADDR_W-1:0]           reg_addr_i,
   input logic [NUM_WIRES-1:0]        wire_o,
   input logic [IDX_W-1:0]            host_idx,
   input logic [RSEL_W-1:0]           rst_sel,
   input logic [NUM_WIRES-1:0]        rst_vals,
   input logic [NUM_WIRES*MODE_W-1:0] modes,
   input logic [NUM_WIRES-1:0]        status
);
   logic fw_src, fw_clr, sel_evt;
   assign fw_src  = reg_we_i && (reg_addr_i == ADDR_W'(REG_SRC));
   assign fw_clr  = reg_we_i && (reg_addr_i == ADDR_W'(REG_STAT));
   assign sel_evt = rst_evt_i[rst_sel];

   a_r2_valid_wires_take_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && upd_index_i == host_idx && !fw_src && !sel_evt)
      |=> ((wire_o & $past(upd_wire_vld_i)) == ($past(upd_wire_val_i) & $past(upd_wire_vld_i))));

   a_r3_foreign_index_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && upd_index_i != host_idx && !fw_src && !sel_evt) |=> $stable(wire_o));

   a_r4_reset_event_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_evt |=> (wire_o == $past(rst_vals)));

   a_r10_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fw_clr |=> (($past(status) & ~status) == '0));

   for (genvar gi = 0; gi < NUM_WIRES; gi++) begin : g_off
      logic off_mode;
      assign off_mode = (modes[gi*MODE_W +: MODE_W] == 3'd0) ||
                        (modes[gi*MODE_W +: MODE_W] > 3'd5);
      a_r9_off_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (off_mode && !status[gi]) |=> !status[gi]);
   end
endmodule

bind vw_group_rx vwg_checker #(
   .NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_vwg_checker (
   .clk_i(clk_i), .rst_ni(rst_ni), .rst_evt_i(rst_evt_i),
   .upd_valid_i(upd_valid_i), .upd_index_i(upd_index_i),
   .upd_wire_vld_i(upd_wire_vld_i), .upd_wire_val_i(upd_wire_val_i),
   .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .wire_o(wire_o),
   .host_idx(host_idx), .rst_sel(rst_sel), .rst_vals(rst_vals),
   .modes(modes), .status(status)
);

// File: tb/vw_group_rx_bench.sv
`timescale 1ns/1ps
module vw_group_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rst_evt = '0;
   logic        upd_valid = 1'b0;
   logic [7:0]  upd_index = '0;
   logic [3:0]  upd_vld = '0;
   logic [3:0]  upd_val = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  wire_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vw_group_rx u_vw_group_rx (
      .clk_i(clk), .rst_ni(rst_n), .rst_evt_i(rst_evt),
      .upd_valid_i(upd_valid), .upd_index_i(upd_index),
      .upd_wire_vld_i(upd_vld), .upd_wire_val_i(upd_val),
      .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .wire_o(wire_o), .irq_o(irq_o)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic reg_wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic host_upd(logic [7:0] idx, logic [3:0] vld, logic [3:0] val);
      @(negedge clk);
      upd_valid = 1'b1; upd_index = idx; upd_vld = vld; upd_val = val;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 wires", 16'(wire_o), 16'h0);
      chk("R1 irq", 16'(irq_o), 16'h0);
      rd(3'd0, d); chk("R1 cfg", d, 16'h0000);
      rd(3'd3, d); chk("R1 status", d, 16'h0);
      rd(3'd4, d); chk("R1 enable", d, 16'h0);
   endtask

   task automatic t_config;
      logic [15:0] d;
      reg_wr(3'd0, 16'h005A);
      rd(3'd0, d); chk("R12 cfg readback", d, 16'h005A);
   endtask

   task automatic t_host;
      logic [15:0] d;
      host_upd(8'h5A, 4'b0101, 4'b1111);
      chk("R2 valid wires set", 16'(wire_o), 16'h5);
      host_upd(8'h5A, 4'b0011, 4'b0010);
      chk("R2 partial update", 16'(wire_o), 16'h6);
      host_upd(8'h5B, 4'b1111, 4'b1001);
      chk("R3 foreign index", 16'(wire_o), 16'h6);
      @(negedge clk);
      upd_index = 8'h5A; upd_vld = 4'b1111; upd_val = 4'b1001; upd_valid = 1'b0;
      @(negedge clk);
      chk("R3 valid low", 16'(wire_o), 16'h6);
      rd(3'd1, d); chk("R5 source readback", d, 16'h6);
   endtask

   task automatic t_fw_write;
      logic [15:0] d;
      reg_wr(3'd1, 16'h0089);
      chk("R5 masked write", 16'(wire_o), 16'hE);
      rd(3'd1, d); chk("R5 read wires", d, 16'hE);
   endtask

   task automatic t_reset_evt;
      reg_wr(3'd0, 16'hA25A);
      @(negedge clk); rst_evt = 4'b0001;
      @(negedge clk); rst_evt = 4'b0000;
      chk("R4 unselected event", 16'(wire_o), 16'hE);
      @(negedge clk); rst_evt = 4'b0100;
      @(negedge clk); rst_evt = 4'b0000;
      chk("R4 selected event", 16'(wire_o), 16'hA);
   endtask

   task automatic t_priority;
      @(negedge clk);
      upd_valid = 1'b1; upd_index = 8'h5A; upd_vld = 4'hF; upd_val = 4'hF;
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0001;
      @(negedge clk);
      upd_valid = 1'b0; reg_we = 1'b0;
      chk("R6 firmware over host", 16'(wire_o), 16'hE);
      @(negedge clk);
      upd_valid = 1'b1; reg_we = 1'b1; reg_wdata = 16'h00F3; rst_evt = 4'b0100;
      @(negedge clk);
      upd_valid = 1'b0; reg_we = 1'b0; rst_evt = 4'b0000;
      chk("R6 reset over all", 16'(wire_o), 16'hA);
   endtask

   task automatic t_edges;
      logic [15:0] d;
      reg_wr(3'd2, 16'h0163);
      rd(3'd3, d); chk("R9 mode change no event", d, 16'h0);
      host_upd(8'h5A, 4'b0111, 4'b0001);
      rd(3'd3, d); chk("R7 rise and fall", d, 16'h3);
      host_upd(8'h5A, 4'b0100, 4'b0100);
      rd(3'd3, d); chk("R7 both edges", d, 16'h7);
      host_upd(8'h5A, 4'b0001, 4'b0000);
      rd(3'd3, d); chk("R7 rise mode ignores fall", d, 16'h7);
      reg_wr(3'd3, 16'h0002);
      rd(3'd3, d); chk("R10 partial clear", d, 16'h5);
      reg_wr(3'd3, 16'h0005);
      rd(3'd3, d); chk("R10 clear rest", d, 16'h0);
   endtask

   task automatic t_collide;
      logic [15:0] d;
      host_upd(8'h5A, 4'b0010, 4'b0010);
      rd(3'd3, d); chk("R7 fall mode ignores rise", d, 16'h0);
      @(negedge clk);
      upd_valid = 1'b1; upd_index = 8'h5A; upd_vld = 4'b0010; upd_val = 4'b0000;
      reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0002;
      @(negedge clk);
      upd_valid = 1'b0; reg_we = 1'b0;
      rd(3'd3, d); chk("R10 set beats clear", d, 16'h2);
      host_upd(8'h5A, 4'b1000, 4'b0000);
      rd(3'd3, d); chk("R9 code 0 quiet", d, 16'h2);
      chk("R2 wires after toggles", 16'(wire_o), 16'h4);
   endtask

   task automatic t_levels;
      logic [15:0] d;
      reg_wr(3'd2, 16'h0000);
      reg_wr(3'd3, 16'h000F);
      reg_wr(3'd1, 16'h000F);
      reg_wr(3'd2, 16'h0F91);
      @(negedge clk);
      rd(3'd3, d); chk("R8 low level sets", d, 16'h1);
      reg_wr(3'd3, 16'h0001);
      rd(3'd3, d); chk("R8 clear while low", d, 16'h1);
      host_upd(8'h5A, 4'hF, 4'hF);
      rd(3'd3, d); chk("R8 high level, R9 codes 6 7", d, 16'h3);
      reg_wr(3'd3, 16'h0001);
      rd(3'd3, d); chk("R8 clear after level gone", d, 16'h2);
   endtask

   task automatic t_irq;
      reg_wr(3'd4, 16'h0002);
      chk("R11 enabled status", 16'(irq_o), 16'h1);
      reg_wr(3'd4, 16'h0005);
      chk("R11 masked status", 16'(irq_o), 16'h0);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_host();
      t_fw_write();
      t_reset_evt();
      t_priority();
      t_edges();
      t_collide();
      t_levels();
      t_irq();
      done = 1'b1;
      finish_run();
   end
endmodule